// File: doc/BRIEF.md
# Floating-Point Hardware Loop Sequencer

This block sits on the instruction path from an integer core to a floating-point unit. In normal operation it passes each floating-point instruction straight to the FPU with a valid/ready handshake. When the core hands it a repetition instruction, the block reads two values from it: a repeat count, taken from an integer register, and a body length. It then takes the next body-length floating-point instructions into a small local buffer and does not forward them.

After the last body instruction is buffered, the block issues the body to the FPU on its own, in capture order. It wraps back to the first entry after the last one, and runs the body once more than the repeat count. The core stays free to run integer work while this happens. The block stalls only the instructions that would break ordering on the floating-point side:
- a new repetition instruction,
- any further floating-point instruction,
- any operation that moves data between the integer and floating-point register files.

Each of these is held until the replay has drained.

Top module: `fp_loop_seq`

## Requirements
- R1: After synchronous reset, `busy`, `fpu_valid` and `len_err` are all low.
- R2: While idle, a floating-point instruction (`in_is_rep` low) is passed through: `fpu_valid` follows `in_valid`, `fpu_instr` equals `in_instr`, and `in_ready` equals `fpu_ready`.
- R3: An accepted repetition instruction whose length field is 1..DEPTH raises `busy` on the next cycle. The next length-field floating-point instructions are then accepted into the buffer. Nothing is presented to the FPU during that capture.
- R4: Replay presents buffer entries in capture order, wrapping to entry 0 after the last one. It delivers exactly length × (count + 1) instructions in total.
- R5: Replay advances only on a cycle with `fpu_valid` and `fpu_ready` both high. While the FPU withholds ready, `fpu_instr` is held unchanged.
- R6: A repetition instruction with a length field of 0 or above DEPTH is accepted and rejected. `len_err` is high for exactly the following cycle, `busy` stays low, nothing is captured, and the next instruction passes straight through.
- R7: While `busy` is high, a repetition instruction sees `in_ready` low.
- R8: An integer/floating-point transfer operation (`in_is_sync` high) sees `in_ready` low while `busy` is high. While idle it passes through like any other floating-point instruction.
- R9: During replay, every incoming instruction sees `in_ready` low.
- R10: `busy` falls on the cycle after the FPU accepts the final replayed instruction. A count of 0 runs the body exactly once.
- R11: A body of a single instruction is valid and is replayed count + 1 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Core presents an instruction |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_instr | input | INSTR_W | Instruction word from the core |
| in_is_rep | input | 1 | Instruction is a repetition instruction |
| in_is_sync | input | 1 | Instruction moves data between integer and FP sides |
| in_rep_count | input | CNT_W | Extra repetitions (the body runs count + 1 times) |
| in_rep_len | input | LEN_W | Body length in instructions |
| fpu_valid | output | 1 | Instruction offered to the FPU |
| fpu_ready | input | 1 | FPU takes the offered instruction |
| fpu_instr | output | INSTR_W | Instruction word to the FPU |
| busy | output | 1 | Capture or replay in progress |
| len_err | output | 1 | One-cycle pulse after an out-of-range body length |

## Verification
The bench aims at the wrap point of the body index, where an off-by-one either repeats the last entry or skips the first one. It also aims at the end of the iteration count: a design that misreads the count as a total would run one pass short, or a count of zero would never finish. Single-entry bodies and a full 16-entry body stress the compare between the capture index and the length. An FPU that withholds ready on alternate cycles exposes a sequencer that advances without a handshake: the logged stream would then miss or duplicate entries. Probes during capture and replay catch a design that lets a new repetition, a transfer operation or a plain instruction slip into the FPU stream. Lengths of 0 and 17 catch a design that starts capture without checking the length.

// File: rtl/fp_loop_pkg.sv
package fp_loop_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_FILL = 2'd1,
        SEQ_PLAY = 2'd2
    } seq_state_e;

    // handshake completions seen by the control block in one cycle
    typedef struct packed {
        logic rep;   // repetition instruction taken while idle
        logic fill;  // body instruction written into the buffer
        logic play;  // buffered instruction taken by the FPU
    } seq_fire_t;

    function automatic logic body_len_ok(input int unsigned len, input int unsigned depth);
        return (len != 0) && (len <= depth);
    endfunction

endpackage

// File: rtl/fp_loop_buf.sv
module fp_loop_buf #(
    parameter int DEPTH   = 16,
    parameter int INSTR_W = 32,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [INSTR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [INSTR_W-1:0] rd_data
);

    logic [INSTR_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/fp_loop_ctrl.sv
module fp_loop_ctrl
    import fp_loop_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_fire_t        fire_i,
    input  logic [CNT_W-1:0] rep_count_i,
    input  logic [LEN_W-1:0] rep_len_i,
    output seq_state_e       state_o,
    output logic [IDX_W-1:0] fill_idx_o,
    output logic [IDX_W-1:0] play_idx_o,
    output logic             busy_o,
    output logic             err_o
);

    seq_state_e       state_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] iter_q;
    logic [IDX_W-1:0] fill_q;
    logic [IDX_W-1:0] play_q;
    logic             err_q;
    logic             fill_last;
    logic             play_last;

    assign fill_last = (LEN_W'(fill_q) + LEN_W'(1)) == len_q;
    assign play_last = (LEN_W'(play_q) + LEN_W'(1)) == len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            len_q   <= '0;
            iter_q  <= '0;
            fill_q  <= '0;
            play_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (fire_i.rep) begin
                        if (body_len_ok(32'(rep_len_i), DEPTH)) begin
                            state_q <= SEQ_FILL;
                            len_q   <= rep_len_i;
                            iter_q  <= rep_count_i;
                            fill_q  <= '0;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                SEQ_FILL: begin
                    if (fire_i.fill) begin
                        if (fill_last) begin
                            state_q <= SEQ_PLAY;
                            play_q  <= '0;
                        end else begin
                            fill_q <= fill_q + IDX_W'(1);
                        end
                    end
                end
                SEQ_PLAY: begin
                    if (fire_i.play) begin
                        if (play_last) begin
                            play_q <= '0;
                            if (iter_q == '0) begin
                                state_q <= SEQ_IDLE;
                            end else begin
                                iter_q <= iter_q - CNT_W'(1);
                            end
                        end else begin
                            play_q <= play_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign state_o    = state_q;
    assign fill_idx_o = fill_q;
    assign play_idx_o = play_q;
    assign busy_o     = (state_q != SEQ_IDLE);
    assign err_o      = err_q;

    // capture index never leaves the declared body
    assert_fill_idx_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_FILL) |-> (LEN_W'(fill_q) < len_q));

    // replay index stays inside the body, so the wrap is taken at the right entry
    assert_play_idx_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_PLAY) |-> (LEN_W'(play_q) < len_q));

    // a rejected length leaves the sequencer idle
    assert_err_idle_R6: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (state_q == SEQ_IDLE));

endmodule

// File: rtl/fp_loop_steer.sv
module fp_loop_steer
    import fp_loop_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  seq_state_e         state_i,
    input  logic               in_valid_i,
    input  logic               in_is_rep_i,
    input  logic               in_is_sync_i,
    input  logic [INSTR_W-1:0] in_instr_i,
    input  logic [INSTR_W-1:0] buf_data_i,
    input  logic               fpu_ready_i,
    output logic               in_ready_o,
    output logic               fpu_valid_o,
    output logic [INSTR_W-1:0] fpu_instr_o,
    output seq_fire_t          fire_o
);

    always_comb begin
        in_ready_o  = 1'b0;
        fpu_valid_o = 1'b0;
        fpu_instr_o = in_instr_i;
        fire_o      = '0;
        case (state_i)
            SEQ_IDLE: begin
                in_ready_o  = in_is_rep_i ? 1'b1 : fpu_ready_i;
                fpu_valid_o = in_valid_i && !in_is_rep_i;
                fire_o.rep  = in_valid_i && in_is_rep_i;
            end
            SEQ_FILL: begin
                in_ready_o  = !(in_is_rep_i || in_is_sync_i);
                fire_o.fill = in_valid_i && in_ready_o;
            end
            SEQ_PLAY: begin
                fpu_valid_o = 1'b1;
                fpu_instr_o = buf_data_i;
                fire_o.play = fpu_ready_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fp_loop_seq.sv
module fp_loop_seq
    import fp_loop_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int INSTR_W = 32,
    parameter int CNT_W   = 8,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [INSTR_W-1:0] in_instr,
    input  logic               in_is_rep,
    input  logic               in_is_sync,
    input  logic [CNT_W-1:0]   in_rep_count,
    input  logic [LEN_W-1:0]   in_rep_len,
    output logic               fpu_valid,
    input  logic               fpu_ready,
    output logic [INSTR_W-1:0] fpu_instr,
    output logic               busy,
    output logic               len_err
);

    seq_state_e         state;
    seq_fire_t          fire;
    logic [IDX_W-1:0]   fill_idx;
    logic [IDX_W-1:0]   play_idx;
    logic [INSTR_W-1:0] buf_data;

    fp_loop_ctrl #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .fire_i      (fire),
        .rep_count_i (in_rep_count),
        .rep_len_i   (in_rep_len),
        .state_o     (state),
        .fill_idx_o  (fill_idx),
        .play_idx_o  (play_idx),
        .busy_o      (busy),
        .err_o       (len_err)
    );

    fp_loop_buf #(
        .DEPTH   (DEPTH),
        .INSTR_W (INSTR_W)
    ) buf_i (
        .clk     (clk),
        .wr_en   (fire.fill),
        .wr_idx  (fill_idx),
        .wr_data (in_instr),
        .rd_idx  (play_idx),
        .rd_data (buf_data)
    );

    fp_loop_steer #(
        .INSTR_W (INSTR_W)
    ) steer_i (
        .state_i      (state),
        .in_valid_i   (in_valid),
        .in_is_rep_i  (in_is_rep),
        .in_is_sync_i (in_is_sync),
        .in_instr_i   (in_instr),
        .buf_data_i   (buf_data),
        .fpu_ready_i  (fpu_ready),
        .in_ready_o   (in_ready),
        .fpu_valid_o  (fpu_valid),
        .fpu_instr_o  (fpu_instr),
        .fire_o       (fire)
    );

    // capture emits nothing toward the FPU
    assert_fill_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_FILL) |-> !fpu_valid);

    // an unaccepted replay offer is held with the same word
    assert_hold_instr_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && fpu_valid && !fpu_ready) |=> (fpu_valid && $stable(fpu_instr)));

    // rejected length never starts a loop
    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        len_err |-> !busy);

    assert_rep_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && in_is_rep) |-> !in_ready);

    assert_sync_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && in_is_sync) |-> !in_ready);

    // while the buffer drives the FPU the core side is closed
    assert_fp_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && fpu_valid) |-> !in_ready);

    // the loop ends only on an FPU acceptance
    assert_end_on_accept_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(fpu_valid && fpu_ready));

endmodule

// File: tb/fp_loop_seq_tb_top.sv
module fp_loop_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic        in_is_rep = 1'b0;
    logic        in_is_sync = 1'b0;
    logic [7:0]  in_rep_count = '0;
    logic [4:0]  in_rep_len = '0;
    logic        fpu_valid;
    logic        fpu_ready;
    logic [31:0] fpu_instr;
    logic        busy;
    logic        len_err;

    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc_n = 0;
    bit          slow_mode = 1'b0;
    int          log_cnt = 0;
    logic [31:0] log_mem [0:1023];

    always #5 clk = ~clk;

    assign fpu_ready = slow_mode ? cyc_n[0] : 1'b1;

    fp_loop_seq dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_instr     (in_instr),
        .in_is_rep    (in_is_rep),
        .in_is_sync   (in_is_sync),
        .in_rep_count (in_rep_count),
        .in_rep_len   (in_rep_len),
        .fpu_valid    (fpu_valid),
        .fpu_ready    (fpu_ready),
        .fpu_instr    (fpu_instr),
        .busy         (busy),
        .len_err      (len_err)
    );

    // FPU model: records every accepted instruction
    always @(posedge clk) begin
        cyc_n <= cyc_n + 1;
        if (!rst && fpu_valid && fpu_ready) begin
            log_mem[log_cnt] <= fpu_instr;
            log_cnt <= log_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] ins, input bit rep, input bit sync,
                        input int cnt, input int len);
        in_valid = 1'b1;
        in_instr = ins;
        in_is_rep = rep;
        in_is_sync = sync;
        in_rep_count = cnt[7:0];
        in_rep_len = len[4:0];
        #1;
        while (!in_ready) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_is_rep = 1'b0;
        in_is_sync = 1'b0;
    endtask

    task automatic probe(input bit rep, input bit sync, input string req, input string what);
        in_valid = 1'b1;
        in_is_rep = rep;
        in_is_sync = sync;
        #1;
        chk(in_ready == 1'b0, req, what, in_ready, 0);
        in_valid = 1'b0;
        in_is_rep = 1'b0;
        in_is_sync = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(fpu_valid == 1'b0, "R1", "fpu_valid after reset", fpu_valid, 0);
        chk(len_err == 1'b0, "R1", "len_err after reset", len_err, 0);
    endtask

    task automatic t_pass();
        int start;
        slow_mode = 1'b0;
        start = log_cnt;
        in_valid = 1'b1;
        in_instr = 32'hA000_0001;
        #1;
        chk(fpu_valid == 1'b1, "R2", "idle fpu_valid", fpu_valid, 1);
        chk(fpu_instr == 32'hA000_0001, "R2", "idle fpu_instr", fpu_instr, 32'hA000_0001);
        chk(in_ready == 1'b1, "R2", "idle in_ready", in_ready, 1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(log_cnt == start + 1, "R2", "idle pass count", log_cnt - start, 1);
        // transfer op while idle flows through
        send(32'hC000_0005, 1'b0, 1'b1, 0, 0);
        chk(log_cnt == start + 2 && log_mem[start + 1] == 32'hC000_0005, "R8",
            "idle sync pass", log_mem[start + 1], 32'hC000_0005);
    endtask

    task automatic t_loop(input int len, input int cnt, input logic [31:0] base,
                          input bit slow, input bit do_probe, input string req);
        int start;
        int bad;
        slow_mode = slow;
        start = log_cnt;
        send(32'hF000_0000, 1'b1, 1'b0, cnt, len);
        chk(busy == 1'b1, "R3", "busy after rep", busy, 1);
        chk(fpu_valid == 1'b0, "R3", "fpu silent in capture", fpu_valid, 0);
        probe(1'b1, 1'b0, "R7", "rep during capture");
        for (int i = 0; i < len; i++) begin
            send(base + 32'(i), 1'b0, 1'b0, 0, 0);
        end
        chk(log_cnt == start, "R3", "nothing issued during capture", log_cnt - start, 0);
        if (do_probe) begin
            chk(fpu_valid == 1'b1, "R4", "replay offer", fpu_valid, 1);
            probe(1'b1, 1'b0, "R7", "rep during replay");
            probe(1'b0, 1'b1, "R8", "sync during replay");
            probe(1'b0, 1'b0, "R9", "fp during replay");
        end
        wait_idle();
        chk(log_cnt - start == len * (cnt + 1), req, "replay count",
            log_cnt - start, len * (cnt + 1));
        bad = 0;
        for (int k = 0; k < len * (cnt + 1); k++) begin
            if (log_mem[start + k] != base + 32'(k % len)) bad++;
        end
        chk(bad == 0, req, "replay order mismatches", bad, 0);
        chk(busy == 1'b0, "R10", "busy low after last accept", busy, 0);
        slow_mode = 1'b0;
    endtask

    task automatic t_reject(input int len);
        int start;
        slow_mode = 1'b0;
        start = log_cnt;
        send(32'hF000_0000, 1'b1, 1'b0, 3, len);
        chk(len_err == 1'b1, "R6", "len_err pulse", len_err, 1);
        chk(busy == 1'b0, "R6", "no busy on bad length", busy, 0);
        send(32'hB000_0007, 1'b0, 1'b0, 0, 0);
        chk(len_err == 1'b0, "R6", "len_err single cycle", len_err, 0);
        chk(log_cnt == start + 1 && log_mem[start] == 32'hB000_0007, "R6",
            "next instr passes", log_cnt - start, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst = 1'b0;
        @(posedge clk); #1;
        t_pass();
        t_loop(3, 2, 32'h1000_0000, 1'b0, 1'b0, "R4");
        t_loop(4, 1, 32'h2000_0000, 1'b1, 1'b1, "R5");
        t_loop(2, 5, 32'h3000_0000, 1'b1, 1'b1, "R4");
        t_loop(1, 3, 32'h4000_0000, 1'b0, 1'b0, "R11");
        t_loop(2, 0, 32'h5000_0000, 1'b0, 1'b0, "R10");
        t_loop(16, 1, 32'h6000_0000, 1'b1, 1'b0, "R4");
        t_reject(0);
        t_reject(17);
        t_pass();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule